// File: doc/BRIEF.md
# Variable-Length Instruction Flow Sequencer

This block steers program flow in a small signal-processing core. It reads 18-bit instruction words from a program ROM. It holds the program counter and a small stack of return addresses. Through a fixed cycle schedule it tells the datapath which instruction is current and when to act on it.

Bit 17 of each instruction word is a length flag. When the flag is set, the sequencer reads a second word that holds a constant or a branch target. After one or two fetch cycles comes one decode cycle. An ordinary instruction then gets a single execute cycle. The vector-filter instruction instead enters a streaming phase. In that phase a filter strobe is raised on every cycle until the datapath reports the last element.

Flow-control instructions can jump, call or return. Each of these actions can be made conditional on a masked set of external flags, on the nonzero state of the loop counters, or on both.

Top module: `iflow_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer returns to the fetch state with the program counter at 0 and an empty return stack. After that edge `rom_addr` is 0 and both strobes are low.
- R2: A single-word instruction (bit 17 = 0), other than the filter instruction, takes exactly three cycles: fetch, decode, execute. `exec_stb` is high only in the execute cycle. The next instruction is read from the following address.
- R3: A double-word instruction (bit 17 = 1) adds one fetch cycle, so it takes four cycles. During execute, `ext_word` holds the second word and the program counter has moved on by 2. For a single-word instruction, `ext_word` reads 0.
- R4: The class is taken from bits 16..14 and reported on `op_class` from the execute or stream phase onward. The codes are:
  - 000 gives NOP (0), unless bits 13..11 are 111, which gives FILTER (6).
  - 001, 010 and 011 give LOAD (1).
  - 110 gives STORE (2).
  - 100 gives MOVE (3).
  - 111 gives ALU (4).
  - 101 gives FLOW (5).
- R5: After its decode cycle, the filter instruction raises `filt_stb` on every cycle. The cycle in which `filt_last` is sampled high is the last one. A filter of L elements therefore takes 2 + L cycles, or 3 + L when it is double-word.
- R6: A FLOW instruction has these fields:
  - bit 13: jump
  - bit 12: call
  - bit 11: return
  - bits 5..4: counter mask
  - bits 3..0: flag mask

  The condition is true when both masks are zero, or when any flag bit is set under its mask, or when any counter-nonzero bit is set under its mask. If the condition is false, execution continues in sequence. If it is true, the priority order is return, then call, then jump. The target is bits 5..0 of the second word, or 0 for a single-word FLOW.
- R7: A taken call pushes the address that follows the call instruction and branches to the target. A taken return branches to the most recently pushed address and removes it.
- R8: The return stack holds 4 entries. A fifth push overwrites the oldest entry. A return on an empty stack branches to address 0.
- R9: `exec_stb` and `filt_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_addr | output | ADDR_W | Program ROM address (the program counter) |
| rom_data | input | 18 | ROM word at `rom_addr`, same cycle |
| flags_in | input | 4 | External condition flags |
| cnt_nz | input | 2 | Loop-counter-nonzero indications |
| filt_last | input | 1 | Last filter element, sampled during streaming |
| instr_word | output | 18 | First word of the current instruction |
| ext_word | output | 18 | Second word, or 0 |
| op_class | output | 3 | Decoded class of the current instruction |
| exec_stb | output | 1 | Execute cycle of an ordinary instruction |
| filt_stb | output | 1 | Streaming cycle of the filter instruction |

## Verification
The assertions check the following on every cycle:
- the strobes never overlap;
- execute is never followed directly by another execute;
- a set length flag always leads into the second fetch;
- streaming holds until `filt_last`;
- a return lands on the address the stack offered;
- the stack count saturates when full and stays at zero when empty.

Some behaviour only the bench scenarios can show, by comparing each executed instruction against an instruction-level model of the program:
- the exact cycle counts for each form of instruction;
- correct class decoding;
- the branch decisions made under random flags;
- the order of call and return through overflow and underflow of the stack.

// File: rtl/iflow_seq_pkg.sv
// Shared types and field positions for the instruction flow sequencer.
// Assumes 18-bit instruction words with the field layout given in the brief.
package iflow_seq_pkg;
    localparam int WORD_W  = 18;
    localparam int FLAG_W  = 4;
    localparam int NCNT    = 2;
    localparam int BIT_LEN = 17;
    localparam int BIT_JMP = 13;
    localparam int BIT_CAL = 12;
    localparam int BIT_RET = 11;
    localparam int FMASK_LO = 0;
    localparam int CMASK_LO = 4;

    typedef enum logic [2:0] {
        CL_NOP   = 3'd0,
        CL_LOAD  = 3'd1,
        CL_STORE = 3'd2,
        CL_MOV   = 3'd3,
        CL_ALU   = 3'd4,
        CL_FLOW  = 3'd5,
        CL_FILT  = 3'd6
    } op_class_t;

    typedef enum logic [2:0] {
        S_FETCH  = 3'd0,
        S_FETCH2 = 3'd1,
        S_DECODE = 3'd2,
        S_EXEC   = 3'd3,
        S_STREAM = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic              jmp;
        logic              cal;
        logic              ret;
        logic [FLAG_W-1:0] fmask;
        logic [NCNT-1:0]   cmask;
    } flow_fields_t;
endpackage

// File: rtl/iflow_decode.sv
// Combinational class decoder and flow-field extractor.
// Assumes the word is the first word of an instruction; it holds no state.
module iflow_decode
    import iflow_seq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output op_class_t         cls,
    output flow_fields_t      ff
);
    // Class from bits 16..14, with the filter form nested inside class 000.
    always_comb begin
        case (word[16:14])
            3'b000:                 cls = (word[13:11] == 3'b111) ? CL_FILT : CL_NOP;
            3'b001, 3'b010, 3'b011: cls = CL_LOAD;
            3'b110:                 cls = CL_STORE;
            3'b100:                 cls = CL_MOV;
            3'b111:                 cls = CL_ALU;
            default:                cls = CL_FLOW;
        endcase
    end

    // Flow fields, which are meaningful only when the class is FLOW.
    always_comb begin
        ff.jmp   = word[BIT_JMP];
        ff.cal   = word[BIT_CAL];
        ff.ret   = word[BIT_RET];
        ff.fmask = word[FMASK_LO +: FLAG_W];
        ff.cmask = word[CMASK_LO +: NCNT];
    end
endmodule

// File: rtl/iflow_branch.sv
// Branch condition evaluator: masked flags and counter state, return > call > jump.
// Assumes 'active' is high only in the execute cycle of a FLOW instruction.
module iflow_branch
    import iflow_seq_pkg::*;
(
    input  logic              active,
    input  flow_fields_t      ff,
    input  logic [FLAG_W-1:0] flags,
    input  logic [NCNT-1:0]   cnt_nz,
    output logic              do_ret,
    output logic              do_call,
    output logic              do_jump
);
    logic uncond;
    logic cond;

    // The condition holds with no mask set, or on any unmasked set flag or counter.
    always_comb begin
        uncond  = (ff.fmask == '0) && (ff.cmask == '0);
        cond    = uncond || (|(ff.fmask & flags)) || (|(ff.cmask & cnt_nz));
        do_ret  = active && cond && ff.ret;
        do_call = active && cond && ff.cal && !ff.ret;
        do_jump = active && cond && ff.jmp && !ff.ret && !ff.cal;
    end
endmodule

// File: rtl/iflow_retstack.sv
// Circular return-address stack; a push when full overwrites the oldest entry,
// and a pop when empty yields address 0. Assumes DEPTH is a power of two
// and that push and pop are never both high.
module iflow_retstack #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] pop_addr
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  top;
    logic [CNT_W-1:0]  cnt;

    // Read port: the top entry, or 0 when the stack is empty.
    always_comb pop_addr = (cnt == '0) ? '0 : mem[top];

    // Pointer, count and storage update on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top <= '0;
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            top <= IDX_W'(top + 1'b1);
            mem[IDX_W'(top + 1'b1)] <= push_addr;
            if (cnt != FULL) cnt <= cnt + 1'b1;
        end else if (pop && cnt != '0) begin
            top <= IDX_W'(top - 1'b1);
            cnt <= cnt - 1'b1;
        end
    end

    p_full_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cnt == FULL) |=> (cnt == FULL));
    p_empty_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/iflow_seq.sv
// Instruction flow sequencer: fetches one- or two-word instructions, runs
// fetch/decode/execute for ordinary instructions and a streaming phase for
// the filter instruction, and updates the program counter and return stack.
// Assumes the ROM answers combinationally in the same cycle.
module iflow_seq
    import iflow_seq_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int STACK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [17:0]       rom_data,
    input  logic [3:0]        flags_in,
    input  logic [1:0]        cnt_nz,
    input  logic              filt_last,
    output logic [17:0]       instr_word,
    output logic [17:0]       ext_word,
    output logic [2:0]        op_class,
    output logic              exec_stb,
    output logic              filt_stb
);
    seq_state_t        state;
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] instr_q;
    logic [WORD_W-1:0] ext_q;
    op_class_t         cls_q;
    op_class_t         dec_cls;
    flow_fields_t      dec_ff;
    logic              do_ret, do_call, do_jump;
    logic [ADDR_W-1:0] stk_pop_addr;
    logic [ADDR_W-1:0] target;

    iflow_decode u_dec (
        .word (instr_q),
        .cls  (dec_cls),
        .ff   (dec_ff)
    );

    iflow_branch u_br (
        .active  (state == S_EXEC && cls_q == CL_FLOW),
        .ff      (dec_ff),
        .flags   (flags_in),
        .cnt_nz  (cnt_nz),
        .do_ret  (do_ret),
        .do_call (do_call),
        .do_jump (do_jump)
    );

    iflow_retstack #(.DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_call),
        .pop       (do_ret),
        .push_addr (pc),
        .pop_addr  (stk_pop_addr)
    );

    // The branch target is the low bits of the second word (0 when absent).
    always_comb target = ext_q[ADDR_W-1:0];

    // Outputs taken straight from the sequencer state.
    always_comb begin
        rom_addr   = pc;
        instr_word = instr_q;
        ext_word   = ext_q;
        op_class   = cls_q;
        exec_stb   = (state == S_EXEC);
        filt_stb   = (state == S_STREAM);
    end

    // Sequencer state machine and program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_FETCH;
            pc      <= '0;
            instr_q <= '0;
            ext_q   <= '0;
            cls_q   <= CL_NOP;
        end else begin
            case (state)
                S_FETCH: begin
                    instr_q <= rom_data;
                    ext_q   <= '0;
                    pc      <= pc + 1'b1;
                    state   <= rom_data[BIT_LEN] ? S_FETCH2 : S_DECODE;
                end
                S_FETCH2: begin
                    ext_q <= rom_data;
                    pc    <= pc + 1'b1;
                    state <= S_DECODE;
                end
                S_DECODE: begin
                    cls_q <= dec_cls;
                    state <= (dec_cls == CL_FILT) ? S_STREAM : S_EXEC;
                end
                S_EXEC: begin
                    if (do_ret)                 pc <= stk_pop_addr;
                    else if (do_call || do_jump) pc <= target;
                    state <= S_FETCH;
                end
                S_STREAM: begin
                    if (filt_last) state <= S_FETCH;
                end
                default: state <= S_FETCH;
            endcase
        end
    end

    p_reset_pc_r1: assert property (@(posedge clk)
        !rst_n |=> (rom_addr == '0 && !exec_stb && !filt_stb));
    p_stb_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_stb && filt_stb));
    p_exec_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |=> (!exec_stb && !filt_stb));
    p_len_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH && rom_data[BIT_LEN]) |=> (state == S_FETCH2));
    p_filt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_stb && !filt_last) |=> filt_stb);
    p_ret_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        do_ret |=> (rom_addr == $past(stk_pop_addr)));
endmodule

// File: tb/iflow_seq_test.sv
// Self-checking bench: instruction-level model of program flow, driven by
// directed call/return chains and random programs with random flags.
module iflow_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam int ROM_N      = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] rom_addr;
    logic [17:0]   rom_data;
    logic [3:0]    flags_in;
    logic [1:0]    cnt_nz;
    logic          filt_last;
    logic [17:0]   instr_word, ext_word;
    logic [2:0]    op_class;
    logic          exec_stb, filt_stb;

    logic [17:0] rom [ROM_N];
    assign rom_data = rom[rom_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    iflow_seq #(.ADDR_W(AW), .STACK_DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
        .flags_in(flags_in), .cnt_nz(cnt_nz), .filt_last(filt_last),
        .instr_word(instr_word), .ext_word(ext_word), .op_class(op_class),
        .exec_stb(exec_stb), .filt_stb(filt_stb)
    );

    int    n_run = 0, n_fail = 0, cyc = 0, last_done = 0;
    int    fcount = 0, flen = 1, mpc = 0, mtop = 0, mcnt = 0;
    int    mstk [4];
    bit    done = 0;
    string ptag = "R1";

    task automatic check_eq(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Class codes per R4.
    function automatic int exp_class(logic [17:0] w);
        case (w[16:14])
            3'b000:                 return (w[13:11] == 3'b111) ? 6 : 0;
            3'b001, 3'b010, 3'b011: return 1;
            3'b110:                 return 2;
            3'b100:                 return 3;
            3'b111:                 return 4;
            default:                return 5;
        endcase
    endfunction

    function automatic logic [17:0] mk_call(int tgt);
        return {1'b1, 3'b101, 3'b010, 11'd0} | 18'(0 * tgt);
    endfunction

    function automatic logic [17:0] mk_ret();
        return {1'b0, 3'b101, 3'b001, 11'd0};
    endfunction

    function automatic logic [17:0] rand_word();
        logic [31:0] r = $urandom;
        logic        il = ($urandom % 4) == 0;
        int          l;
        case ($urandom % 8)
            0: return {il, 3'b000, 1'b0, r[12:0]};
            1: begin l = 1 + $urandom % 3; return {il, 1'b0, 2'(l), r[13:0]}; end
            2: return {il, 3'b110, r[13:0]};
            3: return {il, 3'b100, r[13:0]};
            4: return {il, 3'b111, r[13:0]};
            7: return {il, 3'b000, 3'b111, r[10:0]};
            default: return {il, 3'b101, r[13:0]};
        endcase
    endfunction

    task automatic tick();
        @(negedge clk);
        cyc++;
    endtask

    // R1: apply reset and check the state seen at the ports.
    task automatic do_reset();
        rst_n = 1'b0; filt_last = 1'b0; flags_in = '0; cnt_nz = '0;
        repeat (3) tick();
        check_eq("R1", "rom_addr in reset", int'(rom_addr), 0);
        check_eq("R1", "exec_stb in reset", int'(exec_stb), 0);
        check_eq("R1", "filt_stb in reset", int'(filt_stb), 0);
        rst_n = 1'b1;
        last_done = cyc - 1;
        mpc = 0; mtop = 0; mcnt = 0; fcount = 0; ptag = "R1";
        flen = 1 + $urandom % 5;
    endtask

    // Check one completed instruction and advance the model.
    task automatic complete(bit is_filt);
        logic [17:0] w = rom[mpc];
        logic        il = w[17];
        int          nxt, tgt, fm, cm, exp_cyc;
        bit          cond;
        string       ctag;
        check_eq(ptag, "instr_word at model pc", int'(instr_word), int'(w));
        check_eq("R3", "ext_word", int'(ext_word), il ? int'(rom[(mpc + 1) % ROM_N]) : 0);
        check_eq("R4", "op_class", int'(op_class), exp_class(w));
        exp_cyc = is_filt ? ((il ? 3 : 2) + flen) : (il ? 4 : 3);
        ctag = is_filt ? "R5" : (il ? "R3" : "R2");
        check_eq(ctag, "cycles for instruction", cyc - last_done, exp_cyc);
        last_done = cyc;
        nxt  = (mpc + (il ? 2 : 1)) % ROM_N;
        ptag = il ? "R3" : "R2";
        if (!is_filt && exp_class(w) == 5) begin
            fm  = int'(w[3:0]);
            cm  = int'(w[5:4]);
            tgt = il ? int'(rom[(mpc + 1) % ROM_N][5:0]) : 0;
            cond = (fm == 0 && cm == 0) || ((fm & int'(flags_in)) != 0) ||
                   ((cm & int'(cnt_nz)) != 0);
            ptag = "R6";
            if (cond) begin
                if (w[11]) begin
                    if (mcnt == 0) begin nxt = 0; ptag = "R8"; end
                    else begin
                        nxt = mstk[mtop]; mtop = (mtop + 3) % 4; mcnt--; ptag = "R7";
                    end
                end else if (w[12]) begin
                    ptag = (mcnt == 4) ? "R8" : "R7";
                    mtop = (mtop + 1) % 4; mstk[mtop] = nxt;
                    if (mcnt < 4) mcnt++;
                    nxt = tgt;
                end else if (w[13]) begin
                    nxt = tgt;
                end
            end
        end
        mpc = nxt;
    endtask

    task automatic run_n(int n);
        int got = 0;
        while (got < n && !done) begin
            tick();
            check_eq("R9", "strobe overlap", int'(exec_stb && filt_stb), 0);
            if (filt_stb) begin
                fcount++;
                if (fcount == flen) begin
                    filt_last = 1'b1;
                    complete(1'b1);
                    got++;
                    fcount = 0;
                    flen = 1 + $urandom % 5;
                end else begin
                    filt_last = 1'b0;
                end
            end else begin
                filt_last = 1'b0;
                if (exec_stb) begin
                    complete(1'b0);
                    got++;
                end else begin
                    flags_in = 4'($urandom);
                    cnt_nz   = 2'($urandom);
                end
            end
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        // Directed: five nested calls (overflow) then returns into underflow (R7, R8).
        for (int i = 0; i < ROM_N; i++) rom[i] = '0;
        rom[0]  = mk_call(0);  rom[1]  = 18'd10;
        rom[10] = mk_call(0);  rom[11] = 18'd20;
        rom[20] = mk_call(0);  rom[21] = 18'd30;
        rom[30] = mk_call(0);  rom[31] = 18'd40;
        rom[40] = mk_call(0);  rom[41] = 18'd50;
        rom[50] = mk_ret();
        rom[42] = mk_ret(); rom[32] = mk_ret(); rom[22] = mk_ret(); rom[12] = mk_ret();
        do_reset();
        run_n(16);
        // Directed: filter and double-word filter followed by a conditional jump (R5, R6).
        for (int i = 0; i < ROM_N; i++) rom[i] = '0;
        rom[0] = {1'b0, 3'b000, 3'b111, 11'd0};
        rom[1] = {1'b1, 3'b000, 3'b111, 11'd0};  rom[2] = 18'd5;
        rom[3] = {1'b1, 3'b101, 3'b100, 5'd0, 2'b01, 4'b0000}; rom[4] = 18'd0;
        do_reset();
        run_n(20);
        // Random programs with random flags and counter states.
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < ROM_N; i++) rom[i] = rand_word();
            do_reset();
            run_n(200);
        end
        done = 1;
        summary();
        $finish;
    end
endmodule